// File: doc/BRIEF.md
# Flag-Selected Stream Packer

This block takes a frame of data words arriving on a valid/ready stream, each word paired with a keep flag supplied by logic upstream, and sends on only the words whose flag is set. The surviving words leave densely packed and in the same relative order they arrived in. After them comes a single terminator beat that marks the end of the frame and reports how many words survived. Words whose flag is clear are thrown away.

A frame is handled in phases, one frame at a time. First the block buffers the words. Next it turns each flag into a one or a zero and runs an exclusive prefix sum over those values, so that each kept word learns its slot in the packed buffer. It then places every kept word into its slot in a single scatter step. Last, it drains the packed buffer. The prefix sum is either a ripple chain or an up-sweep/down-sweep balanced tree, picked by a parameter. A frame closes either on the input last marker or when the buffer of DEPTH words is full, whichever comes first.

Top module: `stream_compactor`

## Requirements
- R1: Each word with keep=1 counts as 1 and each word with keep=0 counts as 0. A kept word is written to the packed slot equal to the exclusive prefix sum of these values at its position. The frame total is the last prefix value plus the last flag.
- R2: Only kept words appear on the output data beats, in their input order. No two kept words map to the same slot.
- R3: After the data beats comes exactly one terminator beat. It has out_last=1, out_count equal to the number of kept words, and out_data=0. Data beats carry out_last=0 and out_count=0.
- R4: A frame with no kept word produces only the terminator beat, with out_count=0.
- R5: A frame ends on a word accepted with in_last=1, or on the DEPTH-th accepted word, whichever comes first. A word that arrives after that starts the next frame.
- R6: in_ready is 0 from the cycle after a frame ends until the cycle after its terminator beat is accepted. Only one frame is in flight.
- R7: While out_valid=1 and out_ready=0, out_valid, out_data, out_last and out_count hold their values into the next cycle.
- R8: After reset, in_ready=1 and out_valid=0.
- R9: The ripple variant (SCAN_ARCH=0) and the balanced-tree variant (SCAN_ARCH=1) produce identical output streams, cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | DATA_W | Input word |
| in_keep | input | 1 | Keep flag for the input word |
| in_last | input | 1 | Input word closes the frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DATA_W | Packed kept word; zero on the terminator |
| out_last | output | 1 | Terminator beat of the frame |
| out_count | output | $clog2(DEPTH+1) | Kept-word count on the terminator, zero otherwise |

## Verification
The bench builds two instances with DEPTH=6 and DATA_W=8: one uses the tree prefix sum and the other the ripple chain, and both are fed the same stream. Because DEPTH is not a power of two, the tree has to pad out to eight leaves. The small depth lets the bench run every one of the 64 keep patterns on full frames closed by the depth limit, and every pattern on short frames of one to five words closed by in_last. The downstream ready signal stalls in a rotating pattern, so holds of the terminator and of the data beats are both reached.

// File: rtl/scmp_pkg.sv
package scmp_pkg;

   typedef enum logic [2:0] {
      ST_FILL    = 3'd0,
      ST_SCAN    = 3'd1,
      ST_SCATTER = 3'd2,
      ST_DRAIN   = 3'd3,
      ST_TAIL    = 3'd4
   } scmp_state_e;

   localparam int SCAN_RIPPLE = 0;
   localparam int SCAN_TREE   = 1;

endpackage

// File: rtl/scmp_prefix_scan.sv
module scmp_prefix_scan #(
   parameter int N    = 8,
   parameter int CW   = 4,
   parameter int ARCH = 1
) (
   input  logic [N-1:0]  flags,
   output logic [CW-1:0] excl [N],
   output logic [CW-1:0] total
);
   localparam int LG = (N > 1) ? $clog2(N) : 1;
   localparam int NP = 1 << LG;

   generate
      if (ARCH == scmp_pkg::SCAN_RIPPLE) begin : g_ripple
         always_comb begin
            logic [CW-1:0] acc;
            acc = '0;
            for (int i = 0; i < N; i++) begin
               excl[i] = acc;
               acc     = acc + {{(CW-1){1'b0}}, flags[i]};
            end
            total = acc;
         end
      end else begin : g_tree
         logic [NP-1:0] fpad;
         assign fpad = NP'(flags);
         always_comb begin
            logic [CW-1:0] t [NP];
            logic [CW-1:0] hold;
            for (int i = 0; i < NP; i++) t[i] = {{(CW-1){1'b0}}, fpad[i]};
            // up-sweep: partial sums climb toward the root
            for (int d = 0; d < LG; d++) begin
               for (int k = 0; k < NP; k += (2 << d)) begin
                  t[k + (2 << d) - 1] = t[k + (2 << d) - 1] + t[k + (1 << d) - 1];
               end
            end
            total     = t[NP-1];
            t[NP-1]   = '0;
            // down-sweep: left child gets parent, right child gets parent plus old left
            for (int d = LG - 1; d >= 0; d--) begin
               for (int k = 0; k < NP; k += (2 << d)) begin
                  hold                = t[k + (1 << d) - 1];
                  t[k + (1 << d) - 1] = t[k + (2 << d) - 1];
                  t[k + (2 << d) - 1] = t[k + (2 << d) - 1] + hold;
               end
            end
            for (int i = 0; i < N; i++) excl[i] = t[i];
         end
      end
   endgenerate

endmodule

// File: rtl/scmp_scatter.sv
module scmp_scatter #(
   parameter int N  = 8,
   parameter int DW = 8,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] words [N],
   input  logic [N-1:0]  flags,
   input  logic [CW-1:0] addr  [N],
   output logic [DW-1:0] packed_q [N]
);

   genvar j;
   generate
      for (j = 0; j < N; j++) begin : g_slot
         logic [N-1:0]  hit;
         logic [DW-1:0] pick;
         always_comb begin
            pick = '0;
            for (int i = 0; i < N; i++) begin
               hit[i] = flags[i] && (addr[i] == CW'(j));
               if (hit[i]) pick = pick | words[i];
            end
         end
         always_ff @(posedge clk) begin
            if (!rst_n)    packed_q[j] <= '0;
            else if (load) packed_q[j] <= pick;
         end
         // R2: at most one kept word claims any slot
         p_slot_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
            load |-> $onehot0(hit));
      end
   endgenerate

endmodule

// File: rtl/stream_compactor.sv
module stream_compactor
   import scmp_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 8,
   parameter int SCAN_ARCH = 1,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_keep,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic [CW-1:0]     out_count
);

   generate
      if (DEPTH < 2)       begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (DATA_W < 1)      begin : g_bad_width $error("DATA_W must be at least 1"); end
      if (SCAN_ARCH != SCAN_RIPPLE && SCAN_ARCH != SCAN_TREE)
                           begin : g_bad_arch  $error("SCAN_ARCH must be 0 or 1"); end
   endgenerate

   scmp_state_e       st;
   logic [IW-1:0]     fill_idx;
   logic [CW-1:0]     rd_idx;
   logic [DATA_W-1:0] word_q [DEPTH];
   logic [DEPTH-1:0]  keep_q;
   logic [CW-1:0]     scan_w [DEPTH];
   logic [CW-1:0]     addr_q [DEPTH];
   logic [CW-1:0]     total_w, total_q;
   logic [DATA_W-1:0] packed_q [DEPTH];

   scmp_prefix_scan #(.N(DEPTH), .CW(CW), .ARCH(SCAN_ARCH)) u_scan (
      .flags (keep_q),
      .excl  (scan_w),
      .total (total_w)
   );

   scmp_scatter #(.N(DEPTH), .DW(DATA_W), .CW(CW)) u_scatter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (st == ST_SCATTER),
      .words    (word_q),
      .flags    (keep_q),
      .addr     (addr_q),
      .packed_q (packed_q)
   );

   logic take_in, frame_end;
   assign in_ready  = (st == ST_FILL);
   assign take_in   = in_valid && in_ready;
   assign frame_end = in_last || (fill_idx == IW'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (take_in) word_q[fill_idx] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_FILL;
         fill_idx <= '0;
         rd_idx   <= '0;
         keep_q   <= '0;
         total_q  <= '0;
         for (int i = 0; i < DEPTH; i++) addr_q[i] <= '0;
      end else begin
         unique case (st)
            ST_FILL: if (take_in) begin
               keep_q[fill_idx] <= in_keep;
               if (frame_end) st <= ST_SCAN;
               else           fill_idx <= fill_idx + IW'(1);
            end
            ST_SCAN: begin
               for (int i = 0; i < DEPTH; i++) addr_q[i] <= scan_w[i];
               total_q <= total_w;
               st      <= ST_SCATTER;
            end
            ST_SCATTER: begin
               rd_idx <= '0;
               st     <= (total_q == '0) ? ST_TAIL : ST_DRAIN;
            end
            ST_DRAIN: if (out_ready) begin
               if (rd_idx == total_q - CW'(1)) st <= ST_TAIL;
               else                           rd_idx <= rd_idx + CW'(1);
            end
            ST_TAIL: if (out_ready) begin
               st       <= ST_FILL;
               fill_idx <= '0;
               keep_q   <= '0;
            end
            default: st <= ST_FILL;
         endcase
      end
   end

   always_comb begin
      out_valid = (st == ST_DRAIN) || (st == ST_TAIL);
      out_last  = (st == ST_TAIL);
      out_count = (st == ST_TAIL) ? total_q : '0;
      out_data  = '0;
      if (st == ST_DRAIN) begin
         for (int i = 0; i < DEPTH; i++)
            if (rd_idx == CW'(i)) out_data = packed_q[i];
      end
   end

   // R1: scanned total agrees with last prefix value plus last flag
   p_total_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SCATTER) |-> (total_q == addr_q[DEPTH-1] + {{(CW-1){1'b0}}, keep_q[DEPTH-1]}));

   // R3: terminator carries zero data
   p_tail_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_data == '0));

   // R5: fill index never runs past the buffer
   p_fill_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FILL) |-> (int'(fill_idx) < DEPTH));

   // R6: input closed right after a frame-ending word
   p_in_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_in && in_last) |=> !in_ready);

   // R7: stalled output beat holds
   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                     $stable(out_last) && $stable(out_count)));

endmodule

// File: tb/tb_stream_compactor.sv
module tb_stream_compactor;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 6;
   localparam int CW     = $clog2(DEPTH + 1);
   localparam int LIMIT  = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_keep = 1'b0, in_last = 1'b0, out_ready = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic in_ready, out_valid, out_last;
   logic [DATA_W-1:0] out_data;
   logic [CW-1:0] out_count;
   logic in_ready_r, out_valid_r, out_last_r;
   logic [DATA_W-1:0] out_data_r;
   logic [CW-1:0] out_count_r;

   int total = 0, bad = 0, cyc = 0;
   bit timed_out = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   stream_compactor #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SCAN_ARCH(1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_keep(in_keep), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .out_count(out_count));

   stream_compactor #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SCAN_ARCH(0)) dut_r (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_r),
      .in_data(in_data), .in_keep(in_keep), .in_last(in_last),
      .out_valid(out_valid_r), .out_ready(out_ready), .out_data(out_data_r),
      .out_last(out_last_r), .out_count(out_count_r));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] word_of(input int f, input int i);
      return DATA_W'(f * 7 + i * 29 + 3);
   endfunction

   task automatic run_frame(input int f, input int len, input int pat, input bit use_last);
      logic [DATA_W-1:0] exp_q [DEPTH];
      int k = 0, n = 0;
      bit done = 0, stalled = 0;
      logic [DATA_W-1:0] held_d;
      bit held_l;
      for (int i = 0; i < len; i++)
         if (pat[i]) begin exp_q[k] = word_of(f, i); k++; end
      // send phase
      for (int i = 0; i < len; i++) begin
         bit acc = 0;
         in_valid = 1'b1; in_data = word_of(f, i); in_keep = pat[i];
         in_last  = use_last && (i == len - 1);
         while (!acc) begin
            acc = in_ready;
            @(negedge clk);
            if (cyc > LIMIT) begin timed_out = 1; return; end
         end
      end
      in_valid = 1'b0; in_last = 1'b0; in_keep = 1'b0;
      check(in_ready == 1'b0, "R6 in_ready low after frame end", int'(in_ready), 0);
      // drain phase
      while (!done) begin
         out_ready = ((cyc + f) % 3) != 0;
         check({out_valid, out_data, out_last, out_count} ==
               {out_valid_r, out_data_r, out_last_r, out_count_r},
               "R9 tree vs ripple", int'(out_data), int'(out_data_r));
         if (stalled)
            check(out_valid && out_data == held_d && out_last == held_l,
                  "R7 stalled beat held", int'(out_data), int'(held_d));
         stalled = out_valid && !out_ready;
         held_d = out_data; held_l = out_last;
         if (out_valid && out_ready) begin
            if (!out_last) begin
               if (n < k)
                  check(out_data == exp_q[n], "R1/R2 packed word order", int'(out_data), int'(exp_q[n]));
               else
                  check(1'b0, "R2 extra data beat", n, k);
               check(out_count == '0, "R3 count zero on data beat", int'(out_count), 0);
               n++;
            end else begin
               check(int'(out_count) == k, "R3 terminator count", int'(out_count), k);
               if (k == 0) check(n == 0, "R4 empty frame no data beats", n, 0);
               else        check(n == k, "R2 data beat total", n, k);
               check(out_data == '0, "R3 terminator data zero", int'(out_data), 0);
               done = 1;
            end
         end
         @(negedge clk);
         if (cyc > LIMIT) begin timed_out = 1; return; end
      end
      out_ready = 1'b0;
      check(in_ready == 1'b1, "R6 in_ready back after terminator", int'(in_ready), 1);
   endtask

   initial begin
      int f = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R8 reset in_ready", int'(in_ready), 1);
      check(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
      // R5: full frames closed by the depth limit, every keep pattern
      for (int p = 0; p < (1 << DEPTH); p++) begin
         if (!timed_out) run_frame(f, DEPTH, p, 1'b0);
         f++;
      end
      // R5: short frames closed by in_last, every pattern
      for (int len = 1; len < DEPTH; len++)
         for (int p = 0; p < (1 << len); p++) begin
            if (!timed_out) run_frame(f, len, p, 1'b1);
            f++;
         end
      // full frame with in_last on the final word
      if (!timed_out) run_frame(f, DEPTH, 6'b101101, 1'b1);
      if (timed_out) check(1'b0, "watchdog expired", cyc, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule